// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair

This block sits between the register interface of a UART and its bit-level engines. It holds two small queues. The transmit queue takes bytes written by the CPU and hands them to the serializer. The receive queue takes bytes from the deserializer, each with four error bits, and returns them to the CPU as 12-bit words. A single mode input selects one of two modes for both queues. In queue mode each side holds `DEPTH` entries. In holding mode each side holds one entry. Changing the mode empties both queues.

The block reports the state of each side through empty and full flags. The receive side also has a sticky overrun flag. When a byte arrives at a full receive queue, it replaces the oldest stored byte, so the queue keeps the newest data. When the CPU writes to a full transmit queue, the byte is dropped and nothing records the loss. Each direction raises an interrupt request when its fill level crosses a threshold chosen by a 2-bit field. The threshold is worked out against the capacity of the current mode.

Top module: `uart_fifo_pair`

## Requirements
- R1: After a synchronous reset, both sides are empty and not full, the overrun flag is 0, the transmit interrupt is 1 and the receive interrupt is 0. The block starts in holding mode.
- R2: In holding mode (`cfg_fifo_en`=0), each side holds one entry. One push makes that side full and one pop makes it empty again.
- R3: In queue mode (`cfg_fifo_en`=1), each side holds `DEPTH` (4) entries and returns them in arrival order. Full is raised only after the fourth push.
- R4: A receive word is `{err[3:0], data[7:0]}`. Bits 11:8 carry the error bits that were pushed with the byte, and bits 7:0 carry the byte.
- R5: A CPU write to a full transmit queue is discarded. The stored contents, the count and all flags stay unchanged.
- R6: A push to a full receive queue replaces the oldest entry and sets `rx_ovr`. The queue stays full.
- R7: `rx_ovr` stays at 1 until a cycle with `ovr_clr`=1 and no new overrun. In that cycle it returns to 0.
- R8: The receive level field uses 0=1/4, 1=1/2, 2=3/4 and 3=full. The resulting thresholds are 1, 2, 3 and 4 entries. `rx_irq` is 1 while the count is at or above the threshold.
- R9: The transmit level field uses 0=3/4, 1=1/2, 2=1/4 and 3=empty. The resulting thresholds are 3, 2, 1 and 0 entries. `tx_irq` is 1 while the count is at or below the threshold.
- R10: In holding mode, thresholds are judged against a depth of 1. `rx_irq` equals "holding register full" and `tx_irq` equals "holding register empty" for every level code.
- R11: In the cycle after `cfg_fifo_en` changes, both queues are empty. A push in the cycle of the change is lost.
- R12: A push and a pop in the same cycle leave the count unchanged. On an empty queue, the pushed byte appears at the pop data output in that same cycle. On a full queue, the head leaves and the new byte joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1 = queue mode, 0 = one-entry holding mode |
| cfg_tx_lvl | input | 2 | Transmit trigger level code |
| cfg_rx_lvl | input | 2 | Receive trigger level code |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| cpu_wr_en | input | 1 | CPU writes a transmit byte |
| cpu_wr_data | input | 8 | Transmit byte |
| cpu_rd_en | input | 1 | CPU consumes the head receive word |
| cpu_rd_data | output | 12 | Head receive word {err, data} |
| ser_pop | input | 1 | Serializer takes the head transmit byte |
| ser_data | output | 8 | Head transmit byte |
| des_push | input | 1 | Deserializer delivers a byte |
| des_data | input | 8 | Received byte |
| des_err | input | 4 | Error bits for the received byte |
| tx_empty | output | 1 | Transmit side empty |
| tx_full | output | 1 | Transmit side full |
| rx_empty | output | 1 | Receive side empty |
| rx_full | output | 1 | Receive side full |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |

## Verification
The level comparison is tried with every level code on each side, at the count just below each threshold and at the count just above it. This separates an at-or-above comparison from a strict one, and it catches a swapped code mapping. Queueing is tried four ways: in holding mode, in queue mode with a distinct byte per slot so that order and overwrite of the oldest entry can be seen, with error bits that differ per entry so that the word layout is pinned down, and with simultaneous push and pop on an empty queue and on a full queue. Mode changes are tried with data pending in both directions, which shows the flush.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Receive threshold in entries: ceil(cap * (code+1) / 4), never below 1
  function automatic int rx_threshold(input int cap, input logic [1:0] code);
    int q;
    q = (cap * (int'(code) + 1) + 3) / 4;
    return (q < 1) ? 1 : q;
  endfunction

  // Transmit threshold in entries: floor(cap * (3-code) / 4)
  function automatic int tx_threshold(input int cap, input logic [1:0] code);
    return (cap * (3 - int'(code))) / 4;
  endfunction

endpackage

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int W         = 8,
  parameter int DEPTH     = 4,
  parameter int OVERWRITE = 0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          deep,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovr_pulse
);
  localparam bit OVW = (OVERWRITE != 0);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, cap;
  logic          bypass, wr_do, rd_do;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap   = deep ? CW'(DEPTH) : CW'(1);
  assign full  = (cnt == cap);
  assign empty = (cnt == '0);
  assign count = cnt;

  always_comb begin
    bypass = push && pop && empty;
    wr_do  = push && !bypass && (!full || pop || OVW);
    rd_do  = (pop && !empty) || (OVW && push && full && !pop);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_do) wr_ptr <= step(wr_ptr);
      if (rd_do) rd_ptr <= step(rd_ptr);
      if (wr_do && !rd_do)      cnt <= cnt + CW'(1);
      else if (rd_do && !wr_do) cnt <= cnt - CW'(1);
    end
  end

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_do) mem[wr_ptr] <= push_data;
  end

  assign pop_data = bypass ? push_data : mem[rd_ptr];

  generate
    if (OVW) begin : g_ovr
      assign ovr_pulse = push && full && !pop && !flush;
      // R6: an overwrite keeps the queue full
      a_r6_stays_full: assert property (@(posedge clk) disable iff (rst)
        (!flush && full && push && !pop) |=> full);
    end else begin : g_drop
      assign ovr_pulse = 1'b0;
      // R5: a dropped write leaves the count untouched
      a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!flush && full && push && !pop) |=> (cnt == $past(cnt)));
    end
  endgenerate

  // R3: count never exceeds the capacity of the current mode
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
  // R12: pass-through on an empty queue leaves it empty
  a_r12_pass_empty: assert property (@(posedge clk) disable iff (rst)
    (!flush && empty && push && pop) |=> empty);

endmodule

// File: rtl/uart_fifo_level.sv
module uart_fifo_level
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IS_RX = 0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          deep,
  input  logic [1:0]    code,
  input  logic [CW-1:0] count,
  output logic          irq
);
  int cap_i;
  assign cap_i = deep ? DEPTH : 1;

  generate
    if (IS_RX != 0) begin : g_rx
      assign irq = (int'(count) >= rx_threshold(cap_i, code));
      // R8: a full receive queue always requests service
      a_r8_full_irq: assert property (@(posedge clk) disable iff (rst)
        (int'(count) == cap_i) |-> irq);
    end else begin : g_tx
      assign irq = (int'(count) <= tx_threshold(cap_i, code));
      // R9: an empty transmit queue always requests data
      a_r9_empty_irq: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> irq);
    end
  endgenerate

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  localparam int WORD_W = DATA_W + ERR_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fifo_en,
  input  logic [1:0]        cfg_tx_lvl,
  input  logic [1:0]        cfg_rx_lvl,
  input  logic              ovr_clr,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [WORD_W-1:0] cpu_rd_data,
  input  logic              ser_pop,
  output logic [DATA_W-1:0] ser_data,
  input  logic              des_push,
  input  logic [DATA_W-1:0] des_data,
  input  logic [ERR_W-1:0]  des_err,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic          en_q, flush, rx_ovr_set, tx_ovr_unused;
  logic [CW-1:0] tx_cnt, rx_cnt;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= cfg_fifo_en;
  end
  assign flush = (cfg_fifo_en != en_q);

  uart_fifo_core #(.W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(0)) tx_q (
    .clk(clk), .rst(rst), .flush(flush), .deep(en_q),
    .push(cpu_wr_en), .push_data(cpu_wr_data),
    .pop(ser_pop), .pop_data(ser_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .ovr_pulse(tx_ovr_unused)
  );

  uart_fifo_core #(.W(WORD_W), .DEPTH(DEPTH), .OVERWRITE(1)) rx_q (
    .clk(clk), .rst(rst), .flush(flush), .deep(en_q),
    .push(des_push), .push_data({des_err, des_data}),
    .pop(cpu_rd_en), .pop_data(cpu_rd_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .ovr_pulse(rx_ovr_set)
  );

  uart_fifo_level #(.DEPTH(DEPTH), .IS_RX(0)) tx_lv (
    .clk(clk), .rst(rst), .deep(en_q), .code(cfg_tx_lvl),
    .count(tx_cnt), .irq(tx_irq)
  );

  uart_fifo_level #(.DEPTH(DEPTH), .IS_RX(1)) rx_lv (
    .clk(clk), .rst(rst), .deep(en_q), .code(cfg_rx_lvl),
    .count(rx_cnt), .irq(rx_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             rx_ovr <= 1'b0;
    else if (rx_ovr_set) rx_ovr <= 1'b1;
    else if (ovr_clr)    rx_ovr <= 1'b0;
  end

  // R7: overrun flag is sticky without a clear
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !ovr_clr) |=> rx_ovr);
  // R7: a clear with no new overrun drops the flag
  a_r7_ovr_clear: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr && !rx_ovr_set) |=> !rx_ovr);
  // R11: a mode change empties both sides
  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_empty && rx_empty));

endmodule

// File: tb/uart_fifo_pair_tb_top.sv
module uart_fifo_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst, cfg_fifo_en, ovr_clr, cpu_wr_en, cpu_rd_en, ser_pop, des_push;
  logic [1:0]  cfg_tx_lvl, cfg_rx_lvl;
  logic [7:0]  cpu_wr_data, ser_data, des_data;
  logic [3:0]  des_err;
  logic [11:0] cpu_rd_data;
  logic        tx_empty, tx_full, rx_empty, rx_full, rx_ovr, tx_irq, rx_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_pair dut_i (
    .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_tx_lvl(cfg_tx_lvl),
    .cfg_rx_lvl(cfg_rx_lvl), .ovr_clr(ovr_clr), .cpu_wr_en(cpu_wr_en),
    .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .ser_pop(ser_pop), .ser_data(ser_data), .des_push(des_push),
    .des_data(des_data), .des_err(des_err), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_ovr(rx_ovr), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // {is_rx, level code, fill count, expected irq}; queue mode, DEPTH 4
  localparam logic [6:0] VEC [16] = '{
    {1'b1, 2'd0, 3'd0, 1'b0}, {1'b1, 2'd0, 3'd1, 1'b1},
    {1'b1, 2'd1, 3'd1, 1'b0}, {1'b1, 2'd1, 3'd2, 1'b1},
    {1'b1, 2'd2, 3'd2, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b1},
    {1'b1, 2'd3, 3'd3, 1'b0}, {1'b1, 2'd3, 3'd4, 1'b1},
    {1'b0, 2'd0, 3'd3, 1'b1}, {1'b0, 2'd0, 3'd4, 1'b0},
    {1'b0, 2'd1, 3'd2, 1'b1}, {1'b0, 2'd1, 3'd3, 1'b0},
    {1'b0, 2'd2, 3'd1, 1'b1}, {1'b0, 2'd2, 3'd2, 1'b0},
    {1'b0, 2'd3, 3'd0, 1'b1}, {1'b0, 2'd3, 3'd1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] b);
    cpu_wr_en = 1'b1; cpu_wr_data = b; tick(); cpu_wr_en = 1'b0;
  endtask

  task automatic rx_push(input logic [3:0] e, input logic [7:0] b);
    des_push = 1'b1; des_err = e; des_data = b; tick(); des_push = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b);
    b = ser_data; ser_pop = 1'b1; tick(); ser_pop = 1'b0;
  endtask

  task automatic rx_read(output logic [11:0] w);
    w = cpu_rd_data; cpu_rd_en = 1'b1; tick(); cpu_rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [11:0] w;
    rst = 1'b1; cfg_fifo_en = 1'b0; cfg_tx_lvl = 2'd1; cfg_rx_lvl = 2'd1;
    ovr_clr = 1'b0; cpu_wr_en = 1'b0; cpu_wr_data = '0; cpu_rd_en = 1'b0;
    ser_pop = 1'b0; des_push = 1'b0; des_data = '0; des_err = '0;
    @(negedge clk);
    do_reset();

    // table walk: R8 / R9 level codes in queue mode
    foreach (VEC[i]) begin
      do_reset();
      cfg_fifo_en = 1'b1; tick();
      cfg_rx_lvl = VEC[i][5:4]; cfg_tx_lvl = VEC[i][5:4];
      for (int k = 0; k < int'(VEC[i][3:1]); k++) begin
        if (VEC[i][6]) rx_push(4'h0, 8'(k)); else cpu_write(8'(k));
      end
      if (VEC[i][6]) chk("R8 rx level", rx_irq, VEC[i][0]);
      else           chk("R9 tx level", tx_irq, VEC[i][0]);
    end
    cfg_fifo_en = 1'b0; cfg_tx_lvl = 2'd1; cfg_rx_lvl = 2'd1;

    // R1 reset state
    do_reset();
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0);   chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_ovr", rx_ovr, 0);     chk("R1 tx_irq", tx_irq, 1);
    chk("R1 rx_irq", rx_irq, 0);

    // R2 / R10 holding mode on transmit
    cpu_write(8'hA1);
    chk("R2 tx_full", tx_full, 1); chk("R2 tx_empty", tx_empty, 0);
    chk("R10 tx_irq held", tx_irq, 0);
    cpu_write(8'hA2);
    chk("R5 holding drop full", tx_full, 1);
    tx_take(b);
    chk("R2 held byte", b, 8'hA1);
    chk("R2 tx_empty after pop", tx_empty, 1);
    chk("R10 tx_irq empty", tx_irq, 1);

    // R10 / R6 holding mode on receive
    cfg_rx_lvl = 2'd3;
    rx_push(4'h3, 8'h5A);
    chk("R10 rx_irq held", rx_irq, 1); chk("R2 rx_full", rx_full, 1);
    rx_push(4'hC, 8'hB7);
    chk("R6 ovr holding", rx_ovr, 1);
    rx_read(w);
    chk("R6 newest kept", w, 12'hCB7);
    chk("R2 rx_empty", rx_empty, 1);
    cfg_rx_lvl = 2'd1;

    // R7 sticky overrun
    tick(); tick();
    chk("R7 ovr held", rx_ovr, 1);
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    chk("R7 ovr cleared", rx_ovr, 0);

    // R11 enabling flushes pending data
    cpu_write(8'h33); rx_push(4'h1, 8'h44);
    cfg_fifo_en = 1'b1; tick();
    chk("R11 tx flushed", tx_empty, 1); chk("R11 rx flushed", rx_empty, 1);

    // R3 / R5 queue mode transmit
    for (int k = 0; k < 4; k++) begin
      cpu_write(8'h10 + 8'(k));
      if (k == 2) chk("R3 not full at 3", tx_full, 0);
    end
    chk("R3 full at 4", tx_full, 1);
    cpu_write(8'h14);
    chk("R5 still full", tx_full, 1);
    for (int k = 0; k < 4; k++) begin
      tx_take(b);
      chk("R3 R5 order", b, 8'h10 + 8'(k));
    end
    chk("R5 empty after 4", tx_empty, 1);

    // R4 / R6 queue mode receive with overwrite
    for (int k = 0; k < 4; k++) rx_push(4'(k + 1), 8'h80 + 8'(k));
    chk("R6 no ovr before", rx_ovr, 0);
    rx_push(4'hA, 8'h55);
    chk("R6 ovr set", rx_ovr, 1); chk("R6 still full", rx_full, 1);
    rx_read(w);
    chk("R4 word layout", w, 12'h281);
    rx_read(w); chk("R6 order 2", w, 12'h382);
    rx_read(w); chk("R6 order 3", w, 12'h483);
    rx_read(w); chk("R6 newest", w, 12'hA55);
    chk("R6 empty", rx_empty, 1);

    // R12 pass-through on empty
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h77; ser_pop = 1'b1;
    #1;
    chk("R12 bypass data", ser_data, 8'h77);
    tick(); cpu_wr_en = 1'b0; ser_pop = 1'b0;
    chk("R12 stays empty", tx_empty, 1);

    // R12 push and pop on full
    for (int k = 0; k < 4; k++) cpu_write(8'h20 + 8'(k));
    cpu_wr_en = 1'b1; cpu_wr_data = 8'h24; ser_pop = 1'b1;
    chk("R12 full head", ser_data, 8'h20);
    tick(); cpu_wr_en = 1'b0; ser_pop = 1'b0;
    chk("R12 stays full", tx_full, 1);
    for (int k = 1; k < 5; k++) begin
      tx_take(b);
      chk("R12 full order", b, 8'h20 + 8'(k));
    end

    // R11 disabling flushes too
    cpu_write(8'h99);
    cfg_fifo_en = 1'b0; tick();
    chk("R11 tx flushed on disable", tx_empty, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule